// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Arbiter

This block sits between a set of peripheral request lines and a processor core. Eighteen request sources are folded onto ten vectors. Each vector has an enable bit and a level-select bit. The arbiter picks one vector to present to the core. Each vector's level is chosen from a restricted pair. The two lowest vectors choose between the top level and the bottom level. Every other vector chooses between the middle level and the bottom level.

A request goes to the core only when its level is strictly above the level currently being serviced. When the core acknowledges, the arbiter latches the entry address of the winning vector and pushes the winner's level onto a small level stack. When the core returns from a handler, the stack is popped and the previous level comes back into force. With nothing in service, any enabled request can be taken.

Top module: `irq_arbiter`

## Requirements
- R1: After synchronous reset, `irq_req` is 0, `svc_lvl` is 0 and `vec_addr` is 03h.
- R2: A vector is pending when its `vec_en` bit is 1 and any of its sources requests. The source-to-vector mapping is: source 0 to vector 0, 1 to 1, 2..4 to 2, 5..6 to 3, 7 to 4, 8..9 to 5, 10..11 to 6, 12..13 to 7, 14..16 to 8, and 17 to 9.
- R3: Level codes are 0 for none, 1 for low, 2 for high and 3 for top. When its `lvl_hi` bit is 1, vector 0 or 1 gets level 3 and vectors 2..9 get level 2. When the bit is 0, the vector gets level 1.
- R4: Among pending vectors that are eligible, the one with the highest level wins.
- R5: Among eligible vectors of equal level, the one with the lowest index wins.
- R6: A vector whose level is equal to or below `svc_lvl` does not raise `irq_req`.
- R7: `irq_req` reflects the inputs one clock edge after they are applied. It is 0 in the cycle after an accepted acknowledge.
- R8: An acknowledge while `irq_req` is 1 loads `vec_addr` with 03h + 8 × the winning index and pushes the winner's level. An acknowledge while `irq_req` is 0 changes nothing, and `vec_addr` otherwise holds its value.
- R9: A return pops one level. A return with nothing in service leaves `svc_lvl` at 0.
- R10: An accepted acknowledge and a return in the same cycle replace the top stack entry with the new level.
- R11: Nesting reaches three levels deep, and each return restores the level that was in force before the matching acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 18 | Request line per source |
| vec_en | input | 10 | Enable per vector |
| lvl_hi | input | 10 | Level choice per vector (1 selects the upper option) |
| irq_ack | input | 1 | Core accepts the presented request |
| irq_ret | input | 1 | Core leaves the current handler |
| irq_req | output | 1 | Registered request to the core |
| vec_addr | output | 8 | Entry address latched at acknowledge |
| svc_lvl | output | 2 | Level now in service (0 when idle) |

## Verification
The acknowledge of a new, higher request and the return from the current handler can land on the same clock edge. The return pops one stack entry and the acknowledge pushes another. The bench services a low-level vector, then raises a high-level one. It asserts acknowledge and return together and expects the service level to become the new level rather than the popped or stacked one. It then expects a single return to bring the level back to idle, which shows that the stack depth did not grow.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_LO   = 2'd1,
    LVL_MID  = 2'd2,
    LVL_TOP  = 2'd3
  } irq_lvl_e;
endpackage

// File: rtl/irq_vec_pend.sv
module irq_vec_pend
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 18,
  parameter int unsigned NUM_VEC     = 10,
  parameter int unsigned NUM_TOP_VEC = 2,
  parameter int unsigned SRC_MAP [NUM_SRC] = '{0,1,2,2,2,3,3,4,5,5,6,6,7,7,8,8,8,9}
) (
  input  logic [NUM_SRC-1:0] src_req,
  input  logic [NUM_VEC-1:0] vec_en,
  input  logic [NUM_VEC-1:0] lvl_hi,
  output logic [NUM_VEC-1:0] pend,
  output irq_lvl_e           vlvl [NUM_VEC]
);
  logic [NUM_VEC-1:0] raw;

  always_comb begin
    raw = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      for (int v = 0; v < NUM_VEC; v++) begin
        if (SRC_MAP[s] == v && src_req[s]) raw[v] = 1'b1;
      end
    end
  end

  assign pend = raw & vec_en;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_lvl
    if (v < NUM_TOP_VEC) begin : g_top
      assign vlvl[v] = lvl_hi[v] ? LVL_TOP : LVL_LO;
    end else begin : g_mid
      assign vlvl[v] = lvl_hi[v] ? LVL_MID : LVL_LO;
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_VEC = 10,
  localparam int unsigned VIDX_W = $clog2(NUM_VEC)
) (
  input  logic [NUM_VEC-1:0] pend,
  input  irq_lvl_e           vlvl [NUM_VEC],
  input  irq_lvl_e           cur,
  output logic               hit,
  output logic [VIDX_W-1:0]  idx,
  output irq_lvl_e           lvl
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    lvl = cur;
    // strict compare: a lower index keeps the slot on a tie, and the
    // starting bar is the in-service level
    for (int v = 0; v < NUM_VEC; v++) begin
      if (pend[v] && (vlvl[v] > lvl)) begin
        hit = 1'b1;
        idx = VIDX_W'(v);
        lvl = vlvl[v];
      end
    end
  end
endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack
  import irq_arb_pkg::*;
#(
  parameter int unsigned STK_DEPTH = 3,
  localparam int unsigned CNT_W = $clog2(STK_DEPTH + 1)
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     push,
  input  irq_lvl_e push_lvl,
  input  logic     pop,
  output irq_lvl_e cur
);
  irq_lvl_e         mem [STK_DEPTH];
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] top_ptr;
  logic [CNT_W-1:0] wr_ptr;
  logic             pop_ok;
  logic             push_ok;

  assign top_ptr = cnt - CNT_W'(1);
  assign pop_ok  = pop && (cnt != '0);
  assign push_ok = push && ((cnt < CNT_W'(STK_DEPTH)) || pop_ok);
  assign wr_ptr  = pop_ok ? top_ptr : cnt;
  assign cur     = (cnt == '0) ? LVL_NONE : mem[top_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (push_ok && !pop_ok) begin
      cnt <= cnt + CNT_W'(1);
    end else if (pop_ok && !push_ok) begin
      cnt <= top_ptr;
    end
  end

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |-> (cnt < CNT_W'(STK_DEPTH)));

  p_empty_ret_r9: assert property (@(posedge clk) disable iff (rst)
    ((cnt == '0) && pop && !push) |=> (cur == LVL_NONE));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 18,
  parameter int unsigned NUM_VEC     = 10,
  parameter int unsigned NUM_TOP_VEC = 2,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned VEC_BASE    = 3,
  parameter int unsigned VEC_STRIDE  = 8,
  parameter int unsigned STK_DEPTH   = 3,
  localparam int unsigned VIDX_W     = $clog2(NUM_VEC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic [NUM_VEC-1:0] vec_en,
  input  logic [NUM_VEC-1:0] lvl_hi,
  input  logic              irq_ack,
  input  logic              irq_ret,
  output logic              irq_req,
  output logic [ADDR_W-1:0] vec_addr,
  output logic [1:0]        svc_lvl
);
  logic [NUM_VEC-1:0] pend;
  irq_lvl_e           vlvl [NUM_VEC];
  irq_lvl_e           cur;
  logic               hit;
  logic [VIDX_W-1:0]  win_idx;
  irq_lvl_e           win_lvl;
  logic [VIDX_W-1:0]  win_idx_q;
  irq_lvl_e           win_lvl_q;
  logic               take;

  irq_vec_pend #(
    .NUM_SRC(NUM_SRC), .NUM_VEC(NUM_VEC), .NUM_TOP_VEC(NUM_TOP_VEC)
  ) u_pend (
    .src_req(src_req), .vec_en(vec_en), .lvl_hi(lvl_hi),
    .pend(pend), .vlvl(vlvl)
  );

  irq_prio_pick #(.NUM_VEC(NUM_VEC)) u_pick (
    .pend(pend), .vlvl(vlvl), .cur(cur),
    .hit(hit), .idx(win_idx), .lvl(win_lvl)
  );

  assign take = irq_ack && irq_req;

  irq_lvl_stack #(.STK_DEPTH(STK_DEPTH)) u_stack (
    .clk(clk), .rst(rst),
    .push(take), .push_lvl(win_lvl_q),
    .pop(irq_ret), .cur(cur)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req   <= 1'b0;
      win_idx_q <= '0;
      win_lvl_q <= LVL_NONE;
      vec_addr  <= ADDR_W'(VEC_BASE);
    end else begin
      irq_req   <= hit && !take;
      win_idx_q <= win_idx;
      win_lvl_q <= win_lvl;
      if (take) vec_addr <= ADDR_W'(VEC_BASE + VEC_STRIDE * win_idx_q);
    end
  end

  assign svc_lvl = cur;

  p_vaddr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(vec_addr));

  p_irq_drop_r7: assert property (@(posedge clk) disable iff (rst)
    take |=> !irq_req);

  p_push_above_r6: assert property (@(posedge clk) disable iff (rst)
    take |-> (win_lvl_q > cur));

  p_addr_grid_r8: assert property (@(posedge clk) disable iff (rst)
    ((32'(vec_addr) - VEC_BASE) % VEC_STRIDE) == 0);
endmodule

// File: tb/tb_irq_arbiter.sv
`timescale 1ns/1ps
module tb_irq_arbiter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [17:0] src_req = '0;
  logic [9:0]  vec_en = '1;
  logic [9:0]  lvl_hi = '0;
  logic        irq_ack = 1'b0;
  logic        irq_ret = 1'b0;
  logic        irq_req;
  logic [7:0]  vec_addr;
  logic [1:0]  svc_lvl;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_arbiter dut (
    .clk(clk), .rst(rst), .src_req(src_req), .vec_en(vec_en),
    .lvl_hi(lvl_hi), .irq_ack(irq_ack), .irq_ret(irq_ret),
    .irq_req(irq_req), .vec_addr(vec_addr), .svc_lvl(svc_lvl)
  );

  // entry: req[44:27] en[26:17] sel[16:7] valid[6] idx[5:2] lvl[1:0]
  localparam int NT = 10;
  localparam logic [44:0] TBL [NT] = '{
    {18'h00001, 10'h3FF, 10'h000, 1'b1, 4'd0, 2'd1},
    {18'h20000, 10'h3FF, 10'h3FF, 1'b1, 4'd9, 2'd2},
    {18'h01008, 10'h3FF, 10'h000, 1'b1, 4'd2, 2'd1},
    {18'h01008, 10'h3FF, 10'h080, 1'b1, 4'd7, 2'd2},
    {18'h04002, 10'h3FF, 10'h102, 1'b1, 4'd1, 2'd3},
    {18'h00020, 10'h3F7, 10'h000, 1'b0, 4'd0, 2'd0},
    {18'h00220, 10'h3F7, 10'h000, 1'b1, 4'd5, 2'd1},
    {18'h00000, 10'h3FF, 10'h000, 1'b0, 4'd0, 2'd0},
    {18'h10000, 10'h3FF, 10'h000, 1'b1, 4'd8, 2'd1},
    {18'h00003, 10'h3FF, 10'h003, 1'b1, 4'd0, 2'd3}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_ack();
    irq_ack = 1'b1;
    tick();
    irq_ack = 1'b0;
  endtask

  task automatic do_ret();
    irq_ret = 1'b1;
    tick();
    irq_ret = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick();
    rst = 1'b0;
    tick();
    chk(irq_req == 1'b0, "R1 irq_req", irq_req, 0);
    chk(svc_lvl == 2'd0, "R1 svc_lvl", svc_lvl, 0);
    chk(vec_addr == 8'h03, "R1 vec_addr", vec_addr, 8'h03);

    // table walk: R2 R3 R4 R5 R8 R9
    for (int i = 0; i < NT; i++) begin
      logic [44:0] e;
      e = TBL[i];
      src_req = e[44:27];
      vec_en  = e[26:17];
      lvl_hi  = e[16:7];
      tick();
      chk(irq_req == e[6], "R2 R4 R5 irq_req", irq_req, e[6]);
      if (e[6]) begin
        do_ack();
        chk(vec_addr == 8'(3 + 8 * e[5:2]), "R8 R4 R5 vec_addr", vec_addr, 3 + 8 * e[5:2]);
        chk(svc_lvl == e[1:0], "R3 svc_lvl", svc_lvl, e[1:0]);
        chk(irq_req == 1'b0, "R7 drop after ack", irq_req, 0);
        src_req = '0;
        do_ret();
        chk(svc_lvl == 2'd0, "R9 pop to idle", svc_lvl, 0);
      end
      src_req = '0;
      tick();
    end
    vec_en = '1;
    lvl_hi = '0;

    // latency R7
    src_req[0] = 1'b1;
    #1;
    chk(irq_req == 1'b0, "R7 before edge", irq_req, 0);
    tick();
    chk(irq_req == 1'b1, "R7 after edge", irq_req, 1);
    do_ack();
    src_req = '0;
    do_ret();
    tick();

    // nesting R6 R11
    src_req[7] = 1'b1;
    tick();
    do_ack();
    chk(vec_addr == 8'h23, "R11 addr lvl1", vec_addr, 8'h23);
    chk(svc_lvl == 2'd1, "R11 lvl1", svc_lvl, 1);
    src_req[5] = 1'b1;
    tick();
    tick();
    chk(irq_req == 1'b0, "R6 equal level blocked", irq_req, 0);
    lvl_hi[9] = 1'b1;
    src_req[17] = 1'b1;
    tick();
    chk(irq_req == 1'b1, "R6 higher level raised", irq_req, 1);
    do_ack();
    chk(vec_addr == 8'h4B, "R11 addr lvl2", vec_addr, 8'h4B);
    chk(svc_lvl == 2'd2, "R11 lvl2", svc_lvl, 2);
    lvl_hi[0] = 1'b1;
    src_req[0] = 1'b1;
    tick();
    chk(irq_req == 1'b1, "R11 top raised", irq_req, 1);
    do_ack();
    chk(vec_addr == 8'h03, "R11 addr lvl3", vec_addr, 8'h03);
    chk(svc_lvl == 2'd3, "R11 lvl3", svc_lvl, 3);
    src_req = '0;
    tick();
    do_ret();
    chk(svc_lvl == 2'd2, "R11 restore 2", svc_lvl, 2);
    do_ret();
    chk(svc_lvl == 2'd1, "R11 restore 1", svc_lvl, 1);
    do_ret();
    chk(svc_lvl == 2'd0, "R11 restore 0", svc_lvl, 0);
    do_ret();
    chk(svc_lvl == 2'd0, "R9 empty return", svc_lvl, 0);
    chk(irq_req == 1'b0, "R9 no request", irq_req, 0);

    // ignored ack R8
    do_ack();
    chk(vec_addr == 8'h03, "R8 ack ignored addr", vec_addr, 8'h03);
    chk(svc_lvl == 2'd0, "R8 ack ignored lvl", svc_lvl, 0);

    // ack and return together R10
    lvl_hi = '0;
    src_req[10] = 1'b1;
    tick();
    do_ack();
    chk(vec_addr == 8'h33, "R10 first addr", vec_addr, 8'h33);
    chk(svc_lvl == 2'd1, "R10 first lvl", svc_lvl, 1);
    lvl_hi[2] = 1'b1;
    src_req[2] = 1'b1;
    tick();
    chk(irq_req == 1'b1, "R10 request up", irq_req, 1);
    irq_ack = 1'b1;
    irq_ret = 1'b1;
    tick();
    irq_ack = 1'b0;
    irq_ret = 1'b0;
    chk(svc_lvl == 2'd2, "R10 replaced lvl", svc_lvl, 2);
    chk(vec_addr == 8'h13, "R10 addr", vec_addr, 8'h13);
    src_req = '0;
    do_ret();
    chk(svc_lvl == 2'd0, "R10 single entry", svc_lvl, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule